// File: doc/BRIEF.md
# Host Bus Type Auto-Detector

This block watches the sampled host control pins after a hardware reset and works out how the host talks to the device. It makes two decisions. The first is the strobe style: either two separate active-low strobes for read and write, or a direction pin paired with a data strobe. The second is the bus style: either a multiplexed address/data bus, where A0 is held low, or a non-multiplexed bus, where A0 carries a real address bit. The two mode flags and a lock flag feed the rest of the host interface decode.

Both decisions start from reset defaults: separate strobes and a multiplexed bus. They are learned from the first host accesses. The first read that the host aims at the device, with chip select active, freezes both decisions. They then stay fixed until the asynchronous reset is asserted again. All inputs are taken as already synchronous to `clk`.

Pin meaning depends on the strobe style:
- With separate strobes, `strb_a_n` is the read strobe and `strb_b_n` is the write strobe.
- With direction plus data strobe, `strb_a_n` is the direction pin (high means read, low means write) and `strb_b_n` is the data strobe.

Top module: `hbd_host_bus_detect`

## Requirements
- R1: While `rst_n` is low, and at once when it falls (no clock needed), the outputs are `ds_style`=0 (separate strobes), `direct_bus`=0 (multiplexed) and `modes_locked`=0. Reset also forgets any odd write seen before it.
- R2: If, while unlocked, `strb_a_n` and `strb_b_n` are both sampled low on the same edge, `ds_style` reads 1 from that edge onward.
- R3: Once `ds_style` is 1 it stays 1 until reset.
- R4: Access decode with `ds_style`=0 is as follows. A read is `strb_a_n`=0 with `strb_b_n`=1. A write is `strb_b_n`=0 with `strb_a_n`=1. Both pins high is idle.
- R5: Access decode with `ds_style`=1 (including the edge on which R2 sets it) is as follows. An access is `strb_b_n`=0. It is a read when `strb_a_n`=1 and a write when `strb_a_n`=0.
- R6: While unlocked, a read with `addr_lsb`=1 sets `direct_bus` to 1 on that edge, but only if a write with `addr_lsb`=1 came on some earlier edge since reset. An odd write alone, or an odd read with no odd write before it, leaves `direct_bus` at 0.
- R7: Once `direct_bus` is 1 it stays 1 until reset.
- R8: While unlocked, a read decoded with `host_sel_n`=0 sets `modes_locked` to 1 on that edge. A read with `host_sel_n`=1 does not lock.
- R9: The read that locks still updates both modes on the same edge. One odd write followed by one odd read to the device therefore gives `direct_bus`=1 and `modes_locked`=1 together.
- R10: While `modes_locked` is 1, no pin activity changes `ds_style`, `direct_bus` or `modes_locked` until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| host_sel_n | input | 1 | Device chip select, active low |
| strb_a_n | input | 1 | Read strobe, or direction pin (high = read) |
| strb_b_n | input | 1 | Write strobe, or data strobe |
| addr_lsb | input | 1 | Host A0 sample |
| ds_style | output | 1 | 1 = direction plus data strobe host |
| direct_bus | output | 1 | 1 = non-multiplexed bus |
| modes_locked | output | 1 | 1 = both decisions are frozen |

## Verification
Two functions can fall on the same edge: locking and a mode decision.

The first case is an odd read with chip select active that closes the odd-write/odd-read sequence. That read both sets the non-multiplexed flag and locks. The bench provokes it by resetting and then giving a direction-plus-strobe write to an odd address. This write also decides the strobe style. The bench then gives one odd read to the device and expects all three outputs high after that single edge.

The opposite case is a pin pattern that would change a mode while the lock is already set. The bench judges it by checking that the outputs stay unchanged. Long constrained-random runs replayed against a cycle model in the bench reach both cases repeatedly.

// File: rtl/hbd_pkg.sv
package hbd_pkg;

  typedef enum logic {
    STYLE_SPLIT = 1'b0,
    STYLE_DIRDS = 1'b1
  } strobe_style_e;

  typedef enum logic {
    BUS_MUX    = 1'b0,
    BUS_DIRECT = 1'b1
  } bus_style_e;

  localparam strobe_style_e STROBE_AT_RESET = STYLE_SPLIT;
  localparam bus_style_e    BUS_AT_RESET    = BUS_MUX;

  typedef struct packed {
    logic rd;
    logic wr;
  } access_t;

  // Both host control pins low together only happens for a direction+strobe write.
  function automatic logic pins_both_low(input logic pin_a_n, input logic pin_b_n);
    return (!pin_a_n) && (!pin_b_n);
  endfunction

  // Classify one sampled pin pair as read, write or idle under a given strobe style.
  function automatic access_t classify(input strobe_style_e style,
                                       input logic pin_a_n,
                                       input logic pin_b_n);
    access_t acc;
    acc = '0;
    if (style == STYLE_DIRDS) begin
      acc.rd = !pin_b_n && pin_a_n;
      acc.wr = !pin_b_n && !pin_a_n;
    end else begin
      acc.rd = !pin_a_n && pin_b_n;
      acc.wr = !pin_b_n && pin_a_n;
    end
    return acc;
  endfunction

endpackage

// File: rtl/hbd_strobe_detect.sv
module hbd_strobe_detect
  import hbd_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          freeze,
  input  logic          pin_a_n,
  input  logic          pin_b_n,
  output logic          both_low,
  output strobe_style_e style_q,
  output strobe_style_e style_d
);

  assign both_low = pins_both_low(pin_a_n, pin_b_n);

  always_comb begin
    style_d = style_q;
    if (!freeze && both_low) style_d = STYLE_DIRDS;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) style_q <= STROBE_AT_RESET;
    else        style_q <= style_d;
  end

endmodule

// File: rtl/hbd_access_decode.sv
module hbd_access_decode
  import hbd_pkg::*;
(
  input  strobe_style_e style,
  input  logic          sel_n,
  input  logic          pin_a_n,
  input  logic          pin_b_n,
  input  logic          a0,
  output logic          evt_rd,
  output logic          evt_wr,
  output logic          evt_odd_rd,
  output logic          evt_odd_wr,
  output logic          evt_dev_rd
);

  access_t acc;

  assign acc        = classify(style, pin_a_n, pin_b_n);
  assign evt_rd     = acc.rd;
  assign evt_wr     = acc.wr;
  assign evt_odd_rd = acc.rd && a0;
  assign evt_odd_wr = acc.wr && a0;
  assign evt_dev_rd = acc.rd && !sel_n;

endmodule

// File: rtl/hbd_bus_detect.sv
module hbd_bus_detect
  import hbd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       freeze,
  input  logic       evt_odd_wr,
  input  logic       evt_odd_rd,
  output logic       odd_wr_seen,
  output logic       evt_bus_set,
  output bus_style_e bus_q
);

  assign evt_bus_set = !freeze && odd_wr_seen && evt_odd_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      odd_wr_seen <= 1'b0;
      bus_q       <= BUS_AT_RESET;
    end else if (!freeze) begin
      if (evt_odd_wr)  odd_wr_seen <= 1'b1;
      if (evt_bus_set) bus_q       <= BUS_DIRECT;
    end
  end

endmodule

// File: rtl/hbd_lock_unit.sv
module hbd_lock_unit (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_dev_rd,
  output logic evt_lock,
  output logic locked_q
);

  assign evt_lock = !locked_q && evt_dev_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        locked_q <= 1'b0;
    else if (evt_lock) locked_q <= 1'b1;
  end

endmodule

// File: rtl/hbd_host_bus_detect.sv
module hbd_host_bus_detect
  import hbd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic host_sel_n,
  input  logic strb_a_n,
  input  logic strb_b_n,
  input  logic addr_lsb,
  output logic ds_style,
  output logic direct_bus,
  output logic modes_locked
);

  strobe_style_e style_q;
  strobe_style_e style_d;
  bus_style_e    bus_q;
  logic          both_low;
  logic          evt_rd;
  logic          evt_wr;
  logic          evt_odd_rd;
  logic          evt_odd_wr;
  logic          evt_dev_rd;
  logic          evt_bus_set;
  logic          evt_lock;
  logic          odd_wr_seen;
  logic          locked_q;
  logic          access_clash;

  hbd_strobe_detect u_strobe (
    .clk      (clk),
    .rst_n    (rst_n),
    .freeze   (locked_q),
    .pin_a_n  (strb_a_n),
    .pin_b_n  (strb_b_n),
    .both_low (both_low),
    .style_q  (style_q),
    .style_d  (style_d)
  );

  // The decoder sees the style decided on this very edge, so a first
  // direction+strobe write already counts as a write.
  hbd_access_decode u_decode (
    .style      (style_d),
    .sel_n      (host_sel_n),
    .pin_a_n    (strb_a_n),
    .pin_b_n    (strb_b_n),
    .a0         (addr_lsb),
    .evt_rd     (evt_rd),
    .evt_wr     (evt_wr),
    .evt_odd_rd (evt_odd_rd),
    .evt_odd_wr (evt_odd_wr),
    .evt_dev_rd (evt_dev_rd)
  );

  hbd_bus_detect u_bus (
    .clk         (clk),
    .rst_n       (rst_n),
    .freeze      (locked_q),
    .evt_odd_wr  (evt_odd_wr),
    .evt_odd_rd  (evt_odd_rd),
    .odd_wr_seen (odd_wr_seen),
    .evt_bus_set (evt_bus_set),
    .bus_q       (bus_q)
  );

  hbd_lock_unit u_lock (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_dev_rd (evt_dev_rd),
    .evt_lock   (evt_lock),
    .locked_q   (locked_q)
  );

  assign access_clash = evt_rd && evt_wr;

  assign ds_style     = (style_q == STYLE_DIRDS);
  assign direct_bus   = (bus_q == BUS_DIRECT);
  assign modes_locked = locked_q;

endmodule

// File: rtl/hbd_checker.sv
module hbd_checker (
  input logic clk,
  input logic rst_n,
  input logic strb_a_n,
  input logic strb_b_n,
  input logic ds_style,
  input logic direct_bus,
  input logic modes_locked,
  input logic evt_lock,
  input logic evt_bus_set,
  input logic evt_rd,
  input logic evt_wr,
  input logic access_clash
);

  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |-> (!ds_style && !direct_bus && !modes_locked));

  assert_both_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!modes_locked && !strb_a_n && !strb_b_n) |=> ds_style);

  assert_strobe_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ds_style |=> ds_style);

  assert_one_access_kind_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(evt_rd && evt_wr) && !access_clash);

  assert_bus_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    evt_bus_set |=> direct_bus);

  assert_bus_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    direct_bus |=> direct_bus);

  assert_lock_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    evt_lock |=> modes_locked);

  assert_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    modes_locked |=> (modes_locked && $stable(ds_style) && $stable(direct_bus)));

endmodule

bind hbd_host_bus_detect hbd_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .strb_a_n     (strb_a_n),
  .strb_b_n     (strb_b_n),
  .ds_style     (ds_style),
  .direct_bus   (direct_bus),
  .modes_locked (modes_locked),
  .evt_lock     (evt_lock),
  .evt_bus_set  (evt_bus_set),
  .evt_rd       (evt_rd),
  .evt_wr       (evt_wr),
  .access_clash (access_clash)
);

// File: tb/tb_hbd_host_bus_detect.sv
`timescale 1ns/1ps
module tb_hbd_host_bus_detect;

  localparam int HALF = 4;
  localparam int WATCHDOG_CYCLES = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_sel_n = 1'b1;
  logic strb_a_n = 1'b1;
  logic strb_b_n = 1'b1;
  logic addr_lsb = 1'b0;
  logic ds_style, direct_bus, modes_locked;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // bench cycle model
  bit m_ds, m_dir, m_lock, m_oddw;

  always #HALF clk = ~clk;

  hbd_host_bus_detect dut (
    .clk(clk), .rst_n(rst_n), .host_sel_n(host_sel_n),
    .strb_a_n(strb_a_n), .strb_b_n(strb_b_n), .addr_lsb(addr_lsb),
    .ds_style(ds_style), .direct_bus(direct_bus), .modes_locked(modes_locked)
  );

  // Read/write classification restated per requirement R4/R5 as a truth lookup.
  function automatic bit [1:0] rw_of(bit ds, bit a_n, bit b_n);
    case ({ds, a_n, b_n})
      3'b0_0_1: return 2'b10;  // split read
      3'b0_1_0: return 2'b01;  // split write
      3'b1_1_0: return 2'b10;  // ds read
      3'b1_0_0: return 2'b01;  // ds write
      default:  return 2'b00;
    endcase
  endfunction

  function automatic bit [2:0] expect_now();
    return {m_ds, m_dir, m_lock};
  endfunction

  task automatic model_step(bit cs_n, bit a_n, bit b_n, bit a0);
    bit [1:0] rw;
    if (m_lock) return;
    if (!a_n && !b_n) m_ds = 1;
    rw = rw_of(m_ds, a_n, b_n);
    if (rw[1] && a0 && m_oddw) m_dir = 1;
    if (rw[0] && a0) m_oddw = 1;
    if (rw[1] && !cs_n) m_lock = 1;
  endtask

  task automatic check(string req, bit [2:0] exp);
    bit [2:0] act;
    act = {ds_style, direct_bus, modes_locked};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual {ds,direct,lock}=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(bit cs_n, bit a_n, bit b_n, bit a0);
    @(negedge clk);
    host_sel_n = cs_n; strb_a_n = a_n; strb_b_n = b_n; addr_lsb = a0;
    model_step(cs_n, a_n, b_n, a0);
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    host_sel_n = 1; strb_a_n = 1; strb_b_n = 1; addr_lsb = 0;
    m_ds = 0; m_dir = 0; m_lock = 0; m_oddw = 0;
    #1;
    check("R1", 3'b000);
    @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    #(2 * HALF * WATCHDOG_CYCLES);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog (all requirements): actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0421));
    #1;
    check("R1 reset at time zero", 3'b000);
    do_reset();

    // Separate-strobe multiplexed host: external odd write, then device read.
    cyc(1, 1, 0, 0); check("R4 split write keeps defaults", 3'b000);
    cyc(1, 1, 0, 1); check("R6 odd write alone", 3'b000);
    cyc(1, 0, 1, 0); check("R8 read without select", 3'b000);
    cyc(0, 1, 1, 1); check("R8 idle with select", 3'b000);
    cyc(0, 0, 1, 0); check("R8 even device read locks", 3'b001);
    cyc(1, 0, 0, 1); check("R10 both low after lock", 3'b001);
    cyc(0, 0, 1, 1); check("R10 odd read after lock", 3'b001);

    // Direction+strobe non-multiplexed host, decided and locked together.
    do_reset();
    cyc(1, 0, 0, 1); check("R2 R5 ds write at odd address", 3'b100);
    cyc(1, 1, 1, 0); check("R3 ds sticky while idle", 3'b100);
    cyc(1, 0, 1, 1); check("R5 dir low no strobe is idle", 3'b100);
    cyc(0, 1, 0, 1); check("R9 odd device read sets bus and lock", 3'b111);
    cyc(0, 1, 1, 0); check("R10 stays frozen", 3'b111);

    // Odd read without a prior odd write; reset forgets an earlier odd write.
    do_reset();
    cyc(1, 1, 0, 1); check("R6 odd write recorded", 3'b000);
    do_reset();
    cyc(1, 0, 1, 1); check("R1 R6 odd read after reset no change", 3'b000);
    cyc(1, 1, 0, 1); check("R6 odd write", 3'b000);
    cyc(1, 0, 1, 0); check("R6 even read no change", 3'b000);
    cyc(1, 0, 1, 1); check("R6 odd read sets direct", 3'b010);
    cyc(1, 1, 1, 0); check("R7 direct sticky", 3'b010);

    // Asynchronous reset away from a clock edge.
    cyc(0, 0, 1, 0); check("R8 lock", 3'b011);
    #2;
    rst_n = 0;
    #1;
    check("R1 async clear mid-cycle", 3'b000);
    m_ds = 0; m_dir = 0; m_lock = 0; m_oddw = 0;
    @(negedge clk);
    rst_n = 1;

    // Constrained random runs against the bench model.
    for (int run = 0; run < 40; run++) begin
      do_reset();
      for (int k = 0; k < 40; k++) begin
        bit cs_n, a_n, b_n, a0;
        cs_n = ($urandom % 6) != 0;
        a_n  = ($urandom % 3) != 0;
        b_n  = ($urandom % 3) != 0;
        a0   = ($urandom % 2) != 0;
        cyc(cs_n, a_n, b_n, a0);
        check("R2 R4 R5 R6 R8 R9 R10 random", expect_now());
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule